// File: doc/BRIEF.md
# Fetch Address Selection and Next-PC Prediction

This block works out, every cycle, the address that instruction fetch reads from, and it guesses the address of the next instruction. It keeps no program counter register. The fetch address is rebuilt each cycle from three candidates. The first is a recovery address held by the memory stage, used when a conditional jump turns out to have been wrongly predicted. The second is a return address that a return instruction in the write-back stage loaded from memory. The third is the guess stored in the fetch register.

The guess always follows control transfers. A call or any jump predicts its constant target. Every other instruction predicts the incremented address, and return instructions are not predicted at all. The guess sits in a fetch register that stalls: while stall is high it keeps its value, so the same instruction is fetched again. The block also reports a fetch status taken from a decoded instruction-memory error, an instruction validity flag and the instruction code. It does not check data addresses.

Top module: `fetch_pc_sel`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge that loads the register, `pred_pc` is 0.
- R2: When `mem_icode` is 7 (jump) and `mem_cond` is 0, `fetch_pc` equals `mem_vala`.
- R3: When `wb_icode` is 9 (return) and R2 does not apply, `fetch_pc` equals `wb_valm`.
- R4: When both R2 and R3 conditions hold, `fetch_pc` follows R2 (`mem_vala`).
- R5: When neither condition holds, including a memory-stage jump with `mem_cond` 1, `fetch_pc` equals `pred_pc`.
- R6: On a clock edge with `stall` low, `pred_pc` loads `f_valc` if `f_icode` is 7 (jump) or 8 (call).
- R7: On a clock edge with `stall` low and any other `f_icode`, including 9 (return), `pred_pc` loads `f_valp`.
- R8: On a clock edge with `stall` high, `pred_pc` keeps its value.
- R9: `fetch_stat` is 3 (address error) whenever `imem_err` is 1, whatever the other inputs are.
- R10: `fetch_stat` is 4 (illegal instruction) when `imem_err` is 0 and `f_valid` is 0.
- R11: `fetch_stat` is 2 (halt) when `imem_err` is 0, `f_valid` is 1 and `f_icode` is 0.
- R12: `fetch_stat` is 1 (normal) in all other cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Holds the predicted-PC register |
| f_icode | input | 4 | Code of the instruction being fetched |
| f_valc | input | 64 | Constant field of the fetched instruction |
| f_valp | input | 64 | Address that follows the fetched instruction |
| f_valid | input | 1 | The fetched instruction code is legal |
| imem_err | input | 1 | The fetch address is out of range |
| mem_icode | input | 4 | Instruction code held by the memory-stage register |
| mem_cond | input | 1 | Branch outcome held by the memory-stage register |
| mem_vala | input | 64 | Fall-through address held by the memory-stage register |
| wb_icode | input | 4 | Instruction code held by the write-back register |
| wb_valm | input | 64 | Memory value held by the write-back register |
| fetch_pc | output | 64 | Address to fetch this cycle |
| pred_pc | output | 64 | Predicted PC register |
| fetch_stat | output | 3 | Fetch status code |

## Verification
The checks assume that the stage inputs are settled between clock edges. They also assume that stall and the memory-stage and write-back fields come from registers in the wider pipeline, so that a redirect depends only on what those registers hold this cycle. The stimulus changes every input on the falling clock edge and samples shortly after it, well before the next rising edge. It steps through redirect-only, return-only, both at once, and stalled cycles where a redirect happens while the guess is frozen.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int ICW = 4;
  localparam int STW = 3;

  localparam logic [ICW-1:0] IC_HALT = 4'd0;
  localparam logic [ICW-1:0] IC_JUMP = 4'd7;
  localparam logic [ICW-1:0] IC_CALL = 4'd8;
  localparam logic [ICW-1:0] IC_RET  = 4'd9;

  typedef enum logic [STW-1:0] {
    FS_OK   = 3'd1,
    FS_HALT = 3'd2,
    FS_ADDR = 3'd3,
    FS_ILL  = 3'd4
  } fstat_e;

  function automatic logic follows_target(input logic [ICW-1:0] ic);
    return (ic == IC_JUMP) || (ic == IC_CALL);
  endfunction

  function automatic logic is_wrong_guess(input logic [ICW-1:0] ic, input logic cond);
    return (ic == IC_JUMP) && !cond;
  endfunction
endpackage

// File: rtl/fpc_select.sv
module fpc_select #(
  parameter int AW = 64
) (
  input  logic [fpc_pkg::ICW-1:0] mem_icode,
  input  logic                    mem_cond,
  input  logic [AW-1:0]           mem_vala,
  input  logic [fpc_pkg::ICW-1:0] wb_icode,
  input  logic [AW-1:0]           wb_valm,
  input  logic [AW-1:0]           guess,
  output logic                    redirect,
  output logic                    ret_seen,
  output logic [AW-1:0]           pc
);
  import fpc_pkg::*;

  assign redirect = is_wrong_guess(mem_icode, mem_cond);
  assign ret_seen = (wb_icode == IC_RET);

  always_comb begin
    if (redirect)      pc = mem_vala;
    else if (ret_seen) pc = wb_valm;
    else               pc = guess;
  end
endmodule

// File: rtl/fpc_predict.sv
module fpc_predict #(
  parameter int AW = 64
) (
  input  logic [fpc_pkg::ICW-1:0] icode,
  input  logic [AW-1:0]           valc,
  input  logic [AW-1:0]           valp,
  output logic [AW-1:0]           next_guess
);
  import fpc_pkg::*;
  assign next_guess = follows_target(icode) ? valc : valp;
endmodule

// File: rtl/fpc_status.sv
module fpc_status (
  input  logic [fpc_pkg::ICW-1:0] icode,
  input  logic                    valid,
  input  logic                    addr_err,
  output logic [fpc_pkg::STW-1:0] stat
);
  import fpc_pkg::*;
  fstat_e s;
  always_comb begin
    if (addr_err)              s = FS_ADDR;
    else if (!valid)           s = FS_ILL;
    else if (icode == IC_HALT) s = FS_HALT;
    else                       s = FS_OK;
  end
  assign stat = s;
endmodule

// File: rtl/fpc_hold_reg.sv
module fpc_hold_reg #(
  parameter int          W    = 64,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= INIT;
    else if (!hold) q <= d;
  end
endmodule

// File: rtl/fetch_pc_sel.sv
module fetch_pc_sel #(
  parameter int AW = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stall,
  input  logic [fpc_pkg::ICW-1:0] f_icode,
  input  logic [AW-1:0]           f_valc,
  input  logic [AW-1:0]           f_valp,
  input  logic                    f_valid,
  input  logic                    imem_err,
  input  logic [fpc_pkg::ICW-1:0] mem_icode,
  input  logic                    mem_cond,
  input  logic [AW-1:0]           mem_vala,
  input  logic [fpc_pkg::ICW-1:0] wb_icode,
  input  logic [AW-1:0]           wb_valm,
  output logic [AW-1:0]           fetch_pc,
  output logic [AW-1:0]           pred_pc,
  output logic [fpc_pkg::STW-1:0] fetch_stat
);
  logic          redirect;
  logic          ret_seen;
  logic [AW-1:0] next_guess;

  fpc_select #(.AW(AW)) u_sel (
    .mem_icode(mem_icode), .mem_cond(mem_cond), .mem_vala(mem_vala),
    .wb_icode(wb_icode), .wb_valm(wb_valm), .guess(pred_pc),
    .redirect(redirect), .ret_seen(ret_seen), .pc(fetch_pc)
  );

  fpc_predict #(.AW(AW)) u_pred (
    .icode(f_icode), .valc(f_valc), .valp(f_valp), .next_guess(next_guess)
  );

  fpc_hold_reg #(.W(AW), .INIT('0)) u_reg (
    .clk(clk), .rst_n(rst_n), .hold(stall), .d(next_guess), .q(pred_pc)
  );

  fpc_status u_stat (
    .icode(f_icode), .valid(f_valid), .addr_err(imem_err), .stat(fetch_stat)
  );
endmodule

// File: rtl/fetch_pc_sel_chk.sv
module fetch_pc_sel_chk #(
  parameter int AW = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    stall,
  input logic [AW-1:0]           mem_vala,
  input logic [AW-1:0]           wb_valm,
  input logic [AW-1:0]           pred_pc,
  input logic [AW-1:0]           fetch_pc,
  input logic [fpc_pkg::STW-1:0] fetch_stat,
  input logic                    redirect,
  input logic                    ret_seen,
  input logic [AW-1:0]           next_guess
);
  // R2
  redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> fetch_pc == mem_vala);
  // R3
  return_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_seen && !redirect) |-> fetch_pc == wb_valm);
  // R5
  guess_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_seen && !redirect) |-> fetch_pc == pred_pc);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pred_pc));
  // R6
  guess_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> pred_pc == $past(next_guess));
  // R12
  stat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stat >= 3'd1) && (fetch_stat <= 3'd4));
endmodule

bind fetch_pc_sel fetch_pc_sel_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .mem_vala(mem_vala),
  .wb_valm(wb_valm), .pred_pc(pred_pc), .fetch_pc(fetch_pc),
  .fetch_stat(fetch_stat), .redirect(redirect), .ret_seen(ret_seen),
  .next_guess(next_guess)
);

// File: tb/fetch_pc_sel_bench.sv
module fetch_pc_sel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic [3:0]  f_icode = 4'd1;
  logic [63:0] f_valc = '0, f_valp = '0, mem_vala = '0, wb_valm = '0;
  logic        f_valid = 1'b1, imem_err = 1'b0, mem_cond = 1'b0;
  logic [3:0]  mem_icode = 4'd1, wb_icode = 4'd1;
  logic [63:0] fetch_pc, pred_pc;
  logic [2:0]  fetch_stat;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [63:0] pc;
    logic [2:0]  st;
    logic [63:0] pr;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic [63:0] model_pred = '0;

  always #2 clk = ~clk;

  fetch_pc_sel u_fetch_pc_sel (
    .clk(clk), .rst_n(rst_n), .stall(stall), .f_icode(f_icode),
    .f_valc(f_valc), .f_valp(f_valp), .f_valid(f_valid), .imem_err(imem_err),
    .mem_icode(mem_icode), .mem_cond(mem_cond), .mem_vala(mem_vala),
    .wb_icode(wb_icode), .wb_valm(wb_valm), .fetch_pc(fetch_pc),
    .pred_pc(pred_pc), .fetch_stat(fetch_stat)
  );

  task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic st, input logic [3:0] ic, input logic [63:0] c, input logic [63:0] p,
                      input logic vld, input logic aerr, input logic [3:0] mic, input logic mc,
                      input logic [63:0] ma, input logic [3:0] wic, input logic [63:0] wm, input string tag);
    exp_t e;
    @(negedge clk);
    stall = st; f_icode = ic; f_valc = c; f_valp = p; f_valid = vld; imem_err = aerr;
    mem_icode = mic; mem_cond = mc; mem_vala = ma; wb_icode = wic; wb_valm = wm;
    // fetch address per R2/R3/R4/R5
    case (1'b1)
      (mic == 4'd7 && mc == 1'b0): e.pc = ma;
      (wic == 4'd9):               e.pc = wm;
      default:                     e.pc = model_pred;
    endcase
    // status per R9-R12
    if (aerr)           e.st = 3'd3;
    else if (!vld)      e.st = 3'd4;
    else if (ic == 4'd0) e.st = 3'd2;
    else                e.st = 3'd1;
    e.pr = model_pred;
    e.tag = tag;
    sb.push_back(e);
    // R6/R7/R8 model update for the coming edge
    if (!st) model_pred = (ic == 4'd7 || ic == 4'd8) ? c : p;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        cmp(e.tag, "fetch_pc", fetch_pc, e.pc);
        cmp(e.tag, "fetch_stat", {61'd0, fetch_stat}, {61'd0, e.st});
        cmp(e.tag, "pred_pc", pred_pc, e.pr);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    cmp("R1", "pred_pc in reset", pred_pc, 64'h0);
    rst_n = 1'b1;
    #1 cmp("R1", "pred_pc after release", pred_pc, 64'h0);
    // R5 R12 R7: plain instruction
    step(0, 4'd1, 64'hdead, 64'h10, 1, 0, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R5_R7_R12");
    // R6: jump predicts target
    step(0, 4'd7, 64'h100, 64'h19, 1, 0, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R6_jump");
    // R6: call predicts target
    step(0, 4'd8, 64'h200, 64'h109, 1, 0, 4'd6, 0, 64'h0, 4'd1, 64'h0, "R6_call");
    // R8: stall holds
    step(1, 4'd1, 64'h0, 64'h999, 1, 0, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R8_stall");
    // R2 while stalled
    step(1, 4'd2, 64'h0, 64'h888, 1, 0, 4'd7, 0, 64'h55, 4'd1, 64'h0, "R2_redirect");
    // R3 and R7 for return instruction fetched
    step(0, 4'd9, 64'h4444, 64'h300, 1, 0, 4'd1, 0, 64'h0, 4'd9, 64'h777, "R3_R7_ret");
    // R4: both redirect sources
    step(0, 4'd1, 64'h0, 64'h320, 1, 0, 4'd7, 0, 64'haa, 4'd9, 64'hbb, "R4_priority");
    // R5: taken jump in memory stage is not a redirect
    step(0, 4'd1, 64'h0, 64'h330, 1, 0, 4'd7, 1, 64'hcc, 4'd1, 64'h0, "R5_taken");
    // R9: address error dominates
    step(0, 4'd0, 64'h0, 64'h340, 0, 1, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R9_adr");
    // R10: illegal instruction
    step(0, 4'd0, 64'h0, 64'h350, 0, 0, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R10_ins");
    // R11: halt
    step(0, 4'd0, 64'h0, 64'h360, 1, 0, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R11_hlt");
    // R12 and final register value
    step(1, 4'd3, 64'h0, 64'h370, 1, 0, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R12_aok");
    step(0, 4'd1, 64'h0, 64'h380, 1, 0, 4'd1, 0, 64'h0, 4'd1, 64'h0, "R8_final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule